// File: doc/BRIEF.md
# VRAM Block-Copy and Sprite-Table DMA

This block is a transfer engine that sits next to a word-wide video memory. It performs two kinds of copy. A block copy moves a programmable number of words from one video-memory location to another. Each pointer independently counts up or down, one word per clock. A sprite-table copy moves 256 consecutive words out of video memory into a separate sprite attribute table. Software queues this copy, and it then begins at the next start of vertical blank. It can optionally re-arm itself for every following frame.

Software sets the engine up with byte-wide writes into 16-bit registers. Writing the upper byte of the word count launches a block copy. Writing the upper byte of the sprite-table source address queues a sprite-table copy. Each copy kind ends with a one-cycle completion pulse for the video interrupt logic, and a control bit gates each pulse. A host word port gives direct access to video memory, and a read port on the sprite table serves the renderer. The video memory is 16-bit addressed. Any address with bit 15 set is a hole: it reads as zero and ignores writes. The lower half maps onto a parameterised array, and addresses alias modulo its depth.

Top module: `dma_vram_copier`

## Requirements
- R1: After a synchronous reset, the following hold:
  - both completion pulses are low;
  - all registers and both memories hold zero;
  - nothing is queued, and no copy is running.
- R2: A register write uses a select code (0 control, 1 block source, 2 block destination, 3 word count, 4 sprite-table source) and a byte lane (cfg_hi 0 = bits 7:0, 1 = bits 15:8).
  - The control byte has these bits: bit 0 block-done enable, bit 1 sprite-done enable, bit 2 source counts down, bit 3 destination counts down, bit 4 sprite-table auto-repeat.
  - A block copy starts only on the upper-byte write of the word count. A lower-byte write alone moves nothing.
- R3: While a block copy runs, one word per clock goes from the source pointer to the destination pointer. After each word, each pointer steps by +1, or by −1 when its direction bit is set. Pointers wrap modulo 65536.
- R4: A block copy moves exactly as many words as the count held when it started. A count of zero moves 65536 words.
- R5: blk_done is high for exactly one cycle, in the cycle after the clock edge that writes the last word. This happens only if control bit 0 is set.
- R6: A vblank pulse starts a sprite-table copy only when one is queued. An upper-byte write of the sprite-table source queues it. A vblank with nothing queued leaves the table unchanged and raises no pulse.
- R7: A sprite-table copy writes table entry i from video word (source + i), for i = 0 to 255, one entry per clock.
  - sat_done pulses for one cycle after the last entry, if control bit 1 is set.
  - Afterwards the queue is left equal to control bit 4, so with bit 4 set the next vblank copies again.
- R8: A video-memory address with bit 15 set reads as zero and ignores writes, on the host port and on both copy paths.
- R9: A block copy and a sprite-table copy may run at the same time, and each advances one word in the same clock.
- R10: Host reads are combinational. A host write lands on the next clock edge when no block copy is running, and is dropped in any cycle in which a block copy writes.
- R11: A vblank pulse that arrives while a sprite-table copy is running is ignored. The running copy neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register byte write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_hi | input | 1 | Byte lane: 1 = upper byte |
| cfg_data | input | 8 | Register write byte |
| vblank | input | 1 | One-cycle start-of-vertical-blank pulse |
| host_we | input | 1 | Host video-memory write strobe |
| host_addr | input | 16 | Host video-memory word address |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word (combinational) |
| sat_raddr | input | SAT_AW | Sprite-table read index |
| sat_rdata | output | 16 | Sprite-table read word |
| blk_done | output | 1 | Block copy completion pulse |
| sat_done | output | 1 | Sprite-table copy completion pulse |

## Verification
The two functions that can share a clock are the block copy and the sprite-table copy. To provoke this, the bench writes the upper byte of the word count and pulses vblank in the same cycle, with a 300-word copy and a queued table copy. It then judges the result by the completion pulses: the table copy's pulse must arrive after 256 cycles and the block copy's after 300. Finally, the bench compares both memories word for word against a reference model that applies both copies in order.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef logic [15:0] word_t;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_SRC  = 3'd1,
        SEL_DST  = 3'd2,
        SEL_LEN  = 3'd3,
        SEL_SPR  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic spr_repeat;
        logic dst_down;
        logic src_down;
        logic spr_irq_en;
        logic blk_irq_en;
    } ctrl_t;

    // index 1 = upper byte lane, index 0 = lower byte lane
    typedef struct packed {
        logic [1:0] src_wr;
        logic [1:0] dst_wr;
        logic [1:0] len_wr;
        logic [1:0] spr_wr;
    } wr_strobe_t;

    function automatic ctrl_t ctrl_from_bits(input logic [4:0] b);
        ctrl_t c;
        c.blk_irq_en = b[0];
        c.spr_irq_en = b[1];
        c.src_down   = b[2];
        c.dst_down   = b[3];
        c.spr_repeat = b[4];
        return c;
    endfunction

    function automatic word_t step_ptr(input word_t p, input logic down);
        return down ? word_t'(p - 16'd1) : word_t'(p + 16'd1);
    endfunction

    function automatic word_t merge_byte(input word_t old, input logic hi, input logic [7:0] b);
        return hi ? {b, old[7:0]} : {old[15:8], b};
    endfunction

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic              cfg_hi,
    input  logic [4:0]        ctrl_bits,
    output wr_strobe_t        strb,
    output ctrl_t             ctrl
);

    always_comb begin
        strb = '0;
        if (cfg_we) begin
            case (reg_sel_e'(cfg_sel))
                SEL_SRC: strb.src_wr[cfg_hi] = 1'b1;
                SEL_DST: strb.dst_wr[cfg_hi] = 1'b1;
                SEL_LEN: strb.len_wr[cfg_hi] = 1'b1;
                SEL_SPR: strb.spr_wr[cfg_hi] = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (cfg_we && reg_sel_e'(cfg_sel) == SEL_CTRL && !cfg_hi) begin
            ctrl <= ctrl_from_bits(ctrl_bits);
        end
    end

    // R2: the control register has no upper byte
    assert_ctrl_hi_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 3'd0 && cfg_hi) |=> $stable(ctrl));

endmodule

// File: rtl/dma_vram_store.sv
module dma_vram_store
    import dma_pkg::*;
#(
    parameter int MEM_AW = 11,
    parameter int NRD    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NRD-1:0][15:0]  rd_addr,
    output logic [NRD-1:0][15:0]  rd_data,
    input  logic                  pri_en,
    input  word_t                 pri_addr,
    input  word_t                 pri_data,
    input  logic                  sec_en,
    input  word_t                 sec_addr,
    input  word_t                 sec_data
);
    localparam int DEPTH = 1 << MEM_AW;

    word_t mem [DEPTH];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = rd_addr[p][15] ? '0 : mem[rd_addr[p][MEM_AW-1:0]];
        if (MEM_AW < 15) begin : g_sink
            logic unused_hi_bits;
            assign unused_hi_bits = ^rd_addr[p][14:MEM_AW];
        end
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{pri_addr[14:MEM_AW], sec_addr[14:MEM_AW]};

    // priority write port belongs to the block copy; the host port yields
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (pri_en) begin
            if (!pri_addr[15]) mem[pri_addr[MEM_AW-1:0]] <= pri_data;
        end else if (sec_en && !sec_addr[15]) begin
            mem[sec_addr[MEM_AW-1:0]] <= sec_data;
        end
    end

endmodule

// File: rtl/dma_block_copy.sv
module dma_block_copy
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  src_wr,
    input  logic [1:0]  dst_wr,
    input  logic [1:0]  len_wr,
    input  logic [7:0]  cfg_data,
    input  logic        irq_en,
    input  logic        src_down,
    input  logic        dst_down,
    input  word_t       rd_data,
    output word_t       rd_addr,
    output logic        wr_en,
    output word_t       wr_addr,
    output word_t       wr_data,
    output logic        done
);
    word_t src_q, dst_q, len_q;
    logic  act_q;
    word_t src_n, dst_n, len_n;
    logic  act_n, fin;

    always_comb begin
        src_n = src_q;
        dst_n = dst_q;
        len_n = len_q;
        act_n = act_q;
        fin   = 1'b0;
        if (act_q) begin
            src_n = step_ptr(src_q, src_down);
            dst_n = step_ptr(dst_q, dst_down);
            len_n = word_t'(len_q - 16'd1);
            if (len_q == 16'd1) begin
                act_n = 1'b0;
                fin   = 1'b1;
            end
        end
        if (src_wr[0]) src_n = merge_byte(src_n, 1'b0, cfg_data);
        if (src_wr[1]) src_n = merge_byte(src_n, 1'b1, cfg_data);
        if (dst_wr[0]) dst_n = merge_byte(dst_n, 1'b0, cfg_data);
        if (dst_wr[1]) dst_n = merge_byte(dst_n, 1'b1, cfg_data);
        if (len_wr[0]) len_n = merge_byte(len_n, 1'b0, cfg_data);
        if (len_wr[1]) begin
            len_n = merge_byte(len_q, 1'b1, cfg_data);
            act_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            act_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            src_q <= src_n;
            dst_q <= dst_n;
            len_q <= len_n;
            act_q <= act_n;
            done  <= fin & irq_en;
        end
    end

    assign rd_addr = src_q;
    assign wr_en   = act_q;
    assign wr_addr = dst_q;
    assign wr_data = rd_data;

    assert_start_on_len_hi_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> $past(len_wr[1]));

    assert_len_counts_R4: assert property (@(posedge clk) disable iff (rst)
        (act_q && len_wr == 2'b00) |=> len_q == word_t'($past(len_q) - 16'd1));

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(act_q) && $past(len_q) == 16'd1 && $past(irq_en)));

endmodule

// File: rtl/dma_sprite_copy.sv
module dma_sprite_copy
    import dma_pkg::*;
#(
    parameter int SAT_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        spr_wr,
    input  logic [7:0]        cfg_data,
    input  logic              irq_en,
    input  logic              repeat_en,
    input  logic              vblank,
    input  word_t             rd_data,
    output word_t             rd_addr,
    input  logic [SAT_AW-1:0] sat_raddr,
    output word_t             sat_rdata,
    output logic              done
);
    localparam int SAT_DEPTH = 1 << SAT_AW;

    word_t             tbl [SAT_DEPTH];
    word_t             base_q, base_n;
    logic [SAT_AW-1:0] idx_q, idx_n;
    logic              act_q, act_n, queued_q, queued_n, fin;

    always_comb begin
        base_n   = base_q;
        idx_n    = idx_q;
        act_n    = act_q;
        queued_n = queued_q;
        fin      = 1'b0;
        if (act_q) begin
            idx_n = idx_q + 1'b1;
            if (&idx_q) begin
                act_n    = 1'b0;
                fin      = 1'b1;
                queued_n = repeat_en;
            end
        end else if (vblank && queued_q) begin
            act_n = 1'b1;
            idx_n = '0;
        end
        if (spr_wr[0]) base_n = merge_byte(base_n, 1'b0, cfg_data);
        if (spr_wr[1]) begin
            base_n   = merge_byte(base_n, 1'b1, cfg_data);
            queued_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            idx_q    <= '0;
            act_q    <= 1'b0;
            queued_q <= 1'b0;
            done     <= 1'b0;
            for (int i = 0; i < SAT_DEPTH; i++) tbl[i] <= '0;
        end else begin
            base_q   <= base_n;
            idx_q    <= idx_n;
            act_q    <= act_n;
            queued_q <= queued_n;
            done     <= fin & irq_en;
            if (act_q) tbl[idx_q] <= rd_data;
        end
    end

    assign rd_addr   = word_t'(base_q + word_t'(idx_q));
    assign sat_rdata = tbl[sat_raddr];

    assert_start_needs_queue_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> ($past(vblank) && $past(queued_q)));

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(act_q) && (&$past(idx_q)) && $past(irq_en)));

    assert_vblank_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (act_q && vblank && !(&idx_q)) |=> (act_q && idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/dma_vram_copier.sv
module dma_vram_copier
    import dma_pkg::*;
#(
    parameter int MEM_AW = 11,
    parameter int SAT_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic              cfg_hi,
    input  logic [7:0]        cfg_data,
    input  logic              vblank,
    input  logic              host_we,
    input  logic [15:0]       host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic [SAT_AW-1:0] sat_raddr,
    output logic [15:0]       sat_rdata,
    output logic              blk_done,
    output logic              sat_done
);
    localparam int NRD      = 3;
    localparam int P_BLOCK  = 0;
    localparam int P_SPRITE = 1;
    localparam int P_HOST   = 2;

    wr_strobe_t          strb;
    ctrl_t               ctrl;
    logic [NRD-1:0][15:0] rd_addr, rd_data;
    logic                blk_we;
    word_t               blk_waddr, blk_wdata;

    dma_cfg_decode u_dec (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_hi(cfg_hi),
        .ctrl_bits(cfg_data[4:0]), .strb(strb), .ctrl(ctrl)
    );

    dma_block_copy u_blk (
        .clk(clk), .rst(rst),
        .src_wr(strb.src_wr), .dst_wr(strb.dst_wr), .len_wr(strb.len_wr),
        .cfg_data(cfg_data), .irq_en(ctrl.blk_irq_en),
        .src_down(ctrl.src_down), .dst_down(ctrl.dst_down),
        .rd_data(rd_data[P_BLOCK]), .rd_addr(rd_addr[P_BLOCK]),
        .wr_en(blk_we), .wr_addr(blk_waddr), .wr_data(blk_wdata), .done(blk_done)
    );

    dma_sprite_copy #(.SAT_AW(SAT_AW)) u_spr (
        .clk(clk), .rst(rst), .spr_wr(strb.spr_wr), .cfg_data(cfg_data),
        .irq_en(ctrl.spr_irq_en), .repeat_en(ctrl.spr_repeat), .vblank(vblank),
        .rd_data(rd_data[P_SPRITE]), .rd_addr(rd_addr[P_SPRITE]),
        .sat_raddr(sat_raddr), .sat_rdata(sat_rdata), .done(sat_done)
    );

    assign rd_addr[P_HOST] = host_addr;
    assign host_rdata      = rd_data[P_HOST];

    dma_vram_store #(.MEM_AW(MEM_AW), .NRD(NRD)) u_mem (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .pri_en(blk_we), .pri_addr(blk_waddr), .pri_data(blk_wdata),
        .sec_en(host_we), .sec_addr(host_addr), .sec_data(host_wdata)
    );

    // R8: the hole half of the address space always reads zero on the host port
    assert_hole_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        host_addr[15] |-> host_rdata == 16'd0);

endmodule

// File: tb/sim_dma_vram_copier.sv
`timescale 1ns/10ps
module sim_dma_vram_copier;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic        cfg_hi = 1'b0;
    logic [7:0]  cfg_data = 8'd0;
    logic        vblank = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = 16'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic [7:0]  sat_raddr = 8'd0;
    logic [15:0] sat_rdata;
    logic        blk_done, sat_done;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    logic [15:0] vm [0:2047];
    logic [15:0] sm [0:255];

    dma_vram_copier u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_hi(cfg_hi),
        .cfg_data(cfg_data), .vblank(vblank), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sat_raddr(sat_raddr),
        .sat_rdata(sat_rdata), .blk_done(blk_done), .sat_done(sat_done)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 160000) begin
            nfail++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=160000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_rd(input logic [15:0] a);
        return a[15] ? 16'd0 : vm[a[10:0]];
    endfunction

    task automatic model_blk(input logic [15:0] s, input logic [15:0] d, input logic [15:0] len,
                             input logic sd, input logic dd);
        int n = (len == 16'd0) ? 65536 : int'(len);
        for (int i = 0; i < n; i++) begin
            if (!d[15]) vm[d[10:0]] = m_rd(s);
            s = sd ? s - 16'd1 : s + 16'd1;
            d = dd ? d - 16'd1 : d + 16'd1;
        end
    endtask

    task automatic model_sat(input logic [15:0] s);
        for (int i = 0; i < 256; i++) sm[i] = m_rd(s + 16'(i));
    endtask

    task automatic wreg(input logic [2:0] sel, input logic hi, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_hi = hi; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wreg16(input logic [2:0] sel, input logic [15:0] v);
        wreg(sel, 1'b0, v[7:0]);
        wreg(sel, 1'b1, v[15:8]);
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_vblank();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    // k = cycles from the capturing edge until the pulse is seen; 0 if never
    task automatic wait_sig(input int which, input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if ((which == 0) ? blk_done : sat_done) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic cmp_vram(input string tag);
        for (int a = 0; a < 2048; a++) begin
            host_addr = 16'(a);
            #0.2;
            check(tag, {16'd0, host_rdata}, {16'd0, vm[a]});
        end
    endtask

    task automatic cmp_sat(input string tag);
        for (int a = 0; a < 256; a++) begin
            sat_raddr = 8'(a);
            #0.2;
            check(tag, {16'd0, sat_rdata}, {16'd0, sm[a]});
        end
    endtask

    task automatic start_blk(input logic [4:0] ctl, input logic [15:0] s,
                             input logic [15:0] d, input logic [15:0] len);
        wreg(3'd0, 1'b0, {3'b000, ctl});
        wreg16(3'd1, s);
        wreg16(3'd2, d);
        wreg16(3'd3, len);
    endtask

    initial begin
        int k, kb, ks;
        logic [15:0] s, d, len;
        logic [4:0] ctl;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 2048; i++) vm[i] = 16'd0;
        for (int i = 0; i < 256; i++) sm[i] = 16'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 blk_done", {31'd0, blk_done}, 32'd0);
        check("R1 sat_done", {31'd0, sat_done}, 32'd0);
        cmp_vram("R1 vram zero");
        cmp_sat("R1 table zero");

        // R10 host fill, random contents
        for (int a = 0; a < 2048; a++) begin
            vm[a] = 16'($urandom);
            host_wr(16'(a), vm[a]);
        end
        cmp_vram("R10 host fill");

        // R8 hole: host write ignored, reads zero
        host_wr(16'h8010, 16'hDEAD);
        host_addr = 16'h8010; #0.2;
        check("R8 hole read", {16'd0, host_rdata}, 32'd0);
        cmp_vram("R8 hole write ignored");

        // R2 low count byte alone does not start
        wreg(3'd0, 1'b0, 8'h01);
        wreg16(3'd1, 16'h0000);
        wreg16(3'd2, 16'h0500);
        wreg(3'd3, 1'b0, 8'h05);
        wait_sig(0, 20, k);
        check("R2 no start on low byte", k, 0);
        cmp_vram("R2 memory untouched");

        // R3 R4 R5 directed ascending copy
        start_blk(5'h01, 16'h0010, 16'h0400, 16'd20);
        wait_sig(0, 40, k);
        check("R5 done timing", k, 20);
        model_blk(16'h0010, 16'h0400, 16'd20, 1'b0, 1'b0);
        cmp_vram("R3 ascending copy");

        // R3 R5 R8 random directions, enables, lengths
        for (int t = 0; t < 8; t++) begin
            ctl = {1'b0, 4'($urandom)};
            s = 16'($urandom % 2048);
            d = 16'($urandom % 2048);
            len = 16'(1 + $urandom % 40);
            if (t == 7) s = 16'h8000;
            start_blk(ctl, s, d, len);
            wait_sig(0, 60, k);
            check("R5 gated done", k, ctl[0] ? int'(len) : 0);
            model_blk(s, d, len, ctl[2], ctl[3]);
            cmp_vram("R3 random copy");
        end

        // R10 host write dropped while a block copy writes
        start_blk(5'h01, 16'h0000, 16'h0700, 16'd10);
        host_we = 1'b1; host_addr = 16'h0050; host_wdata = ~vm[16'h0050];
        @(negedge clk);
        host_we = 1'b0;
        wait_sig(0, 20, k);
        check("R10 copy done", k, 9);
        model_blk(16'h0000, 16'h0700, 16'd10, 1'b0, 1'b0);
        cmp_vram("R10 host write dropped");

        // R4 count zero moves 65536 words
        start_blk(5'h01, 16'h0000, 16'h0003, 16'd0);
        wait_sig(0, 70000, k);
        check("R4 zero count length", k, 65536);
        model_blk(16'h0000, 16'h0003, 16'd0, 1'b0, 1'b0);
        cmp_vram("R4 zero count memory");

        // R6 vblank with nothing queued
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R6 no transfer unqueued", k, 0);
        cmp_sat("R6 table unchanged");

        // R7 queued single transfer
        wreg(3'd0, 1'b0, 8'h03);
        wreg16(3'd4, 16'h0100);
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R7 table done timing", k, 256);
        model_sat(16'h0100);
        cmp_sat("R7 table contents");
        vm[16'h0100] = 16'h1234;
        host_wr(16'h0100, 16'h1234);
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R7 queue cleared without repeat", k, 0);
        cmp_sat("R7 table kept");

        // R7 auto-repeat
        wreg(3'd0, 1'b0, 8'h13);
        wreg16(3'd4, 16'h07C0);
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R7 repeat first", k, 256);
        model_sat(16'h07C0);
        cmp_sat("R7 repeat first table");
        vm[16'h0205] = 16'hA5A5;
        host_wr(16'h0205, 16'hA5A5);
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R7 repeat second", k, 256);
        model_sat(16'h07C0);
        cmp_sat("R7 repeat second table");

        // R7 pulse gated off, copy still runs (still queued by repeat)
        wreg(3'd0, 1'b0, 8'h10);
        vm[16'h07C1] = 16'h0F0F;
        host_wr(16'h07C1, 16'h0F0F);
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R7 gated table pulse", k, 0);
        model_sat(16'h07C0);
        cmp_sat("R7 gated table contents");

        // R11 vblank during a running table copy
        wreg(3'd0, 1'b0, 8'h02);
        wreg16(3'd4, 16'h0300);
        pulse_vblank();
        wait_sig(1, 100, k);
        check("R11 no early pulse", k, 0);
        pulse_vblank();
        wait_sig(1, 300, k);
        check("R11 length unchanged", k, 154);
        wait_sig(1, 300, k);
        check("R11 no second pulse", k, 0);
        model_sat(16'h0300);
        cmp_sat("R11 table contents");

        // R9 both copies started in the same cycle
        wreg(3'd0, 1'b0, 8'h03);
        wreg16(3'd4, 16'h0380);
        wreg16(3'd1, 16'h0000);
        wreg16(3'd2, 16'h0600);
        wreg(3'd3, 1'b0, 8'h2C);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_hi = 1'b1; cfg_data = 8'h01; vblank = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; vblank = 1'b0;
        kb = 0; ks = 0;
        for (int i = 1; i <= 320; i++) begin
            @(negedge clk);
            if (blk_done && kb == 0) kb = i;
            if (sat_done && ks == 0) ks = i;
        end
        check("R9 table pulse", ks, 256);
        check("R9 block pulse", kb, 300);
        model_blk(16'h0000, 16'h0600, 16'd300, 1'b0, 1'b0);
        model_sat(16'h0380);
        cmp_vram("R9 block memory");
        cmp_sat("R9 table memory");

        summary();
        $finish;
    end
endmodule